// File: doc/BRIEF.md
# Three-Segment Bus Access Guard

This block sits beside a CPU data bus and checks every access against a simple three-zone protection scheme. A fixed address window is split by two programmable borders into a low, a middle and a high segment. Each segment carries its own read, write and execute enables and a bit that selects how a denied access is reported. A denied access either sets a sticky per-segment flag, which drives a maskable interrupt, or requests a power-up-clear style system reset.

Software programs the guard through a small register port. The main control register only accepts a write whose upper byte carries a fixed key. A wrong key is dropped and raises a reset request of its own. A lock bit freezes the whole configuration until the block's reset input is asserted, which is wired to the power-level (brown-out) reset.

Top module: `segGuard`

## Requirements
- R1: After reset the control, flag and both border registers read 0, the permission register reads 0x0777 (every segment fully allowed, all report-select bits clear), and segIrq, pucReq and pwdViol are low.
- R2: A stored border value is the byte address shifted right by four (0x0600 places a border at 0x6000). The low segment spans 0x4400 up to border 1 minus one, the middle segment spans border 1 up to border 2 minus one, and the high segment spans border 2 up to 0x13FFF.
- R3: An access outside the window 0x4400..0x13FFF is never reported, whatever the permissions.
- R4: The permission register (select 4) holds one nibble per segment, low segment in bits 3:0: bit 0 allows reads, bit 1 writes, bit 2 fetches, bit 3 selects reset reporting. busKind 0 is a read, 1 a write, 2 a fetch and 3 no access; an access of a kind whose bit is clear in its segment is denied, and with bit 3 clear it sets that segment's flag (flag register select 1, low segment in bit 0), visible one clock after the access.
- R5: When the denying segment's report-select bit is set, pucReq is high for exactly the one clock after the access and no flag is set.
- R6: While the enable bit (control bit 0) is clear, no access sets a flag or raises pucReq.
- R7: A control write (select 0) takes effect only when bits 15:8 equal 0xA5; it loads enable (bit 0), lock (bit 1) and interrupt enable (bit 4). A write with any other upper byte leaves the control register unchanged and pulses pwdViol high for the one clock after it.
- R8: Writing the flag register clears each flag whose written bit is 0 and keeps those written 1; a flag set by an access in the same clock wins over the clear.
- R9: segIrq is high exactly when the interrupt enable bit is set and at least one flag is set.
- R10: Once lock is set, writes to the control, border and permission registers are ignored until reset; flag clearing still works.
- R11: When border 2 is not above border 1 the middle segment is empty: addresses from border 1 upward belong to the high segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-level reset; the only way to release the lock |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select: 0 control, 1 flags, 2 border 1, 3 border 2, 4 permissions |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Combinational read data of the selected register |
| busValid | input | 1 | Bus access present this clock |
| busKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 none |
| busAddr | input | 20 | Byte address of the access |
| segIrq | output | 1 | Violation interrupt: any flag set while interrupts are enabled |
| pucReq | output | 1 | One-clock reset request for a violation in a reset-reporting segment |
| pwdViol | output | 1 | One-clock reset request for a control write with a wrong key |

## Verification
Every result of an access or register write lands one clock later: flags, pucReq and pwdViol are registered on the edge that samples the stimulus, while segIrq and regRdata follow those registers without delay. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check sees the first cycle the result is due; the one-clock pulses are checked again a cycle later to confirm they have dropped. Register contents are read back through the read port, a settling delay after the select changes.

// File: rtl/segGuardPkg.sv
package segGuardPkg;
  localparam int REG_W   = 16;
  localparam int NUM_SEG = 3;
  localparam int PERM_W  = 4;

  // register select codes
  localparam logic [2:0] SEL_CTRL    = 3'd0;
  localparam logic [2:0] SEL_FLAGS   = 3'd1;
  localparam logic [2:0] SEL_BORDER1 = 3'd2;
  localparam logic [2:0] SEL_BORDER2 = 3'd3;
  localparam logic [2:0] SEL_PERM    = 3'd4;

  // control register fields
  localparam int CTL_EN   = 0;
  localparam int CTL_LOCK = 1;
  localparam int CTL_IE   = 4;

  // permission nibble fields
  localparam int P_RD = 0;
  localparam int P_WR = 1;
  localparam int P_EX = 2;
  localparam int P_VS = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_NONE  = 2'b11
  } accKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrBorder1;
    logic             wrBorder2;
    logic             wrPerm;
    logic [REG_W-1:0] data;
  } cfgStrobe_t;
endpackage

// File: rtl/segGuardDatapath.sv
module segGuardDatapath
  import segGuardPkg::*;
#(
  parameter int              ADDR_W = 20,
  parameter int              SHIFT  = 4,
  parameter logic [ADDR_W-1:0] WIN_LO = 20'h04400,
  parameter logic [ADDR_W-1:0] WIN_HI = 20'h13FFF
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  cfgStrobe_t                  cfg,
  input  logic                        busValid,
  input  logic [1:0]                  busKind,
  input  logic [ADDR_W-1:0]           busAddr,
  output logic [REG_W-1:0]            border1Q,
  output logic [REG_W-1:0]            border2Q,
  output logic [NUM_SEG*PERM_W-1:0]   permQ,
  output logic [NUM_SEG-1:0]          denyIrq,
  output logic [NUM_SEG-1:0]          denyRst
);
  localparam int CMP_W = (ADDR_W > REG_W + SHIFT) ? ADDR_W : REG_W + SHIFT;
  localparam logic [NUM_SEG*PERM_W-1:0] PERM_RST = {NUM_SEG{4'b0111}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      border1Q <= '0;
      border2Q <= '0;
      permQ    <= PERM_RST;
    end else begin
      if (cfg.wrBorder1) border1Q <= cfg.data;
      if (cfg.wrBorder2) border2Q <= cfg.data;
      if (cfg.wrPerm)    permQ    <= cfg.data[NUM_SEG*PERM_W-1:0];
    end
  end

  logic [CMP_W-1:0] addrC, b1C, b2C;
  logic             inWin, midOpen;
  logic [NUM_SEG-1:0] segHit;

  always_comb begin
    addrC   = CMP_W'(busAddr);
    b1C     = CMP_W'(border1Q) << SHIFT;
    b2C     = CMP_W'(border2Q) << SHIFT;
    inWin   = (addrC >= CMP_W'(WIN_LO)) && (addrC <= CMP_W'(WIN_HI));
    midOpen = border2Q > border1Q;
    segHit[0] = inWin && (addrC < b1C);
    segHit[1] = inWin && !segHit[0] && midOpen && (addrC < b2C);
    segHit[2] = inWin && !segHit[0] && !segHit[1];
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic [PERM_W-1:0] nib;
    logic              lacks;
    logic              deny;
    always_comb begin
      nib = permQ[i*PERM_W +: PERM_W];
      unique case (accKind_t'(busKind))
        ACC_READ:  lacks = !nib[P_RD];
        ACC_WRITE: lacks = !nib[P_WR];
        ACC_FETCH: lacks = !nib[P_EX];
        default:   lacks = 1'b0;
      endcase
      deny       = busValid && segHit[i] && lacks;
      denyIrq[i] = deny && !nib[P_VS];
      denyRst[i] = deny &&  nib[P_VS];
    end
  end
endmodule

// File: rtl/segGuardCtrl.sv
module segGuardCtrl
  import segGuardPkg::*;
#(
  parameter logic [7:0] PWD = 8'hA5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [2:0]                regSel,
  input  logic [REG_W-1:0]          regWdata,
  output logic [REG_W-1:0]          regRdata,
  input  logic [REG_W-1:0]          border1Q,
  input  logic [REG_W-1:0]          border2Q,
  input  logic [NUM_SEG*PERM_W-1:0] permQ,
  input  logic [NUM_SEG-1:0]        denyIrq,
  input  logic [NUM_SEG-1:0]        denyRst,
  output cfgStrobe_t                cfg,
  output logic                      segIrq,
  output logic                      pucReq,
  output logic                      pwdViol,
  output logic                      enableQ,
  output logic                      lockQ,
  output logic                      segIeQ,
  output logic [NUM_SEG-1:0]        flagsQ
);
  logic ctrlWr, keyOk, cfgOpen;
  logic [NUM_SEG-1:0] flagKeep, flagSet;

  always_comb begin
    ctrlWr        = regWrEn && (regSel == SEL_CTRL);
    keyOk         = regWdata[REG_W-1:REG_W-8] == PWD;
    cfgOpen       = regWrEn && !lockQ;
    cfg.wrBorder1 = cfgOpen && (regSel == SEL_BORDER1);
    cfg.wrBorder2 = cfgOpen && (regSel == SEL_BORDER2);
    cfg.wrPerm    = cfgOpen && (regSel == SEL_PERM);
    cfg.data      = regWdata;
    flagKeep      = (regWrEn && regSel == SEL_FLAGS) ? regWdata[NUM_SEG-1:0] : '1;
    flagSet       = enableQ ? denyIrq : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      lockQ   <= 1'b0;
      segIeQ  <= 1'b0;
      flagsQ  <= '0;
      pucReq  <= 1'b0;
      pwdViol <= 1'b0;
    end else begin
      if (ctrlWr && keyOk && !lockQ) begin
        enableQ <= regWdata[CTL_EN];
        lockQ   <= regWdata[CTL_LOCK];
        segIeQ  <= regWdata[CTL_IE];
      end
      flagsQ  <= (flagsQ & flagKeep) | flagSet;
      pucReq  <= enableQ && (|denyRst);
      pwdViol <= ctrlWr && !keyOk;
    end
  end

  assign segIrq = segIeQ && (|flagsQ);

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_CTRL: begin
        regRdata[CTL_EN]   = enableQ;
        regRdata[CTL_LOCK] = lockQ;
        regRdata[CTL_IE]   = segIeQ;
      end
      SEL_FLAGS:   regRdata[NUM_SEG-1:0] = flagsQ;
      SEL_BORDER1: regRdata = border1Q;
      SEL_BORDER2: regRdata = border2Q;
      SEL_PERM:    regRdata[NUM_SEG*PERM_W-1:0] = permQ;
      default:     regRdata = '0;
    endcase
  end
endmodule

// File: rtl/segGuard.sv
module segGuard
  import segGuardPkg::*;
#(
  parameter int                ADDR_W = 20,
  parameter int                SHIFT  = 4,
  parameter logic [ADDR_W-1:0] WIN_LO = 20'h04400,
  parameter logic [ADDR_W-1:0] WIN_HI = 20'h13FFF,
  parameter logic [7:0]        PWD    = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              busValid,
  input  logic [1:0]        busKind,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              segIrq,
  output logic              pucReq,
  output logic              pwdViol
);
  cfgStrobe_t                cfg;
  logic [REG_W-1:0]          border1Q, border2Q;
  logic [NUM_SEG*PERM_W-1:0] permQ;
  logic [NUM_SEG-1:0]        denyIrq, denyRst, flagsQ;
  logic                      enableQ, lockQ, segIeQ;

  segGuardCtrl #(.PWD(PWD)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .border1Q(border1Q), .border2Q(border2Q), .permQ(permQ),
    .denyIrq(denyIrq), .denyRst(denyRst), .cfg(cfg),
    .segIrq(segIrq), .pucReq(pucReq), .pwdViol(pwdViol),
    .enableQ(enableQ), .lockQ(lockQ), .segIeQ(segIeQ), .flagsQ(flagsQ)
  );

  segGuardDatapath #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .busValid(busValid), .busKind(busKind), .busAddr(busAddr),
    .border1Q(border1Q), .border2Q(border2Q), .permQ(permQ),
    .denyIrq(denyIrq), .denyRst(denyRst)
  );
endmodule

// File: rtl/segGuardChk.sv
module segGuardChk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regSel,
  input logic [15:0] regWdata,
  input logic        busValid,
  input logic        pucReq,
  input logic        pwdViol,
  input logic        enableQ,
  input logic        lockQ,
  input logic [2:0]  flagsQ,
  input logic [15:0] border1Q,
  input logic [11:0] permQ
);
  // R6: a flag can only appear after a checked access
  p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((flagsQ & ~$past(flagsQ)) != 3'b000) |-> $past(busValid && enableQ));

  // R5: a reset request needs an access while enabled
  p_puc_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    pucReq |-> $past(busValid && enableQ));

  // R7: key-violation pulse follows a bad control write
  p_pwd_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    pwdViol |-> $past(regWrEn && regSel == 3'd0 && regWdata[15:8] != 8'hA5));

  // R10: lock is sticky and freezes configuration
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockQ) |-> lockQ);

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockQ) |-> ($stable(border1Q) && $stable(permQ)));

  // R8: flags only fall on a flag-register write
  p_flag_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flagsQ) & ~flagsQ) != 3'b000) |-> $past(regWrEn && regSel == 3'd1));
endmodule

bind segGuard segGuardChk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWdata(regWdata),
  .busValid(busValid), .pucReq(pucReq), .pwdViol(pwdViol),
  .enableQ(enableQ), .lockQ(lockQ), .flagsQ(flagsQ),
  .border1Q(border1Q), .permQ(permQ)
);

// File: tb/segGuard_tb_top.sv
module segGuard_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, regWrEn, busValid;
  logic [2:0]  regSel;
  logic [15:0] regWdata, regRdata;
  logic [1:0]  busKind;
  logic [19:0] busAddr;
  logic        segIrq, pucReq, pwdViol;

  segGuard dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .busValid(busValid), .busKind(busKind), .busAddr(busAddr),
    .segIrq(segIrq), .pucReq(pucReq), .pwdViol(pwdViol)
  );

  int nChecks = 0;
  int nErr = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(logic [2:0] s, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = s; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(logic [2:0] s, output logic [15:0] v);
    regSel = s;
    #1;
    v = regRdata;
  endtask

  task automatic access(logic [19:0] a, logic [1:0] k);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busKind = k;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  function automatic int expSeg(logic [19:0] a, logic [15:0] b1, logic [15:0] b2);
    int av, lo, hi;
    av = int'(a); lo = int'(b1) * 16; hi = int'(b2) * 16;
    if (av < 'h4400 || av > 'h13FFF) return -1;
    if (av < lo) return 0;
    if (hi > lo && av < hi) return 1;
    return 2;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  logic [19:0] addrs [11];
  initial begin
    logic [15:0] v;
    int e;
    addrs = '{20'h00000, 20'h43FF, 20'h4400, 20'h5FFF, 20'h6000, 20'h6002,
              20'h7FFF, 20'h8000, 20'h13FFF, 20'h14000, 20'hFFFFF};
    rstN = 1'b0; regWrEn = 1'b0; regSel = 3'd0; regWdata = '0;
    busValid = 1'b0; busKind = 2'd0; busAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(0, v); chk("R1 ctrl", v, 0);
    regRd(1, v); chk("R1 flags", v, 0);
    regRd(2, v); chk("R1 border1", v, 0);
    regRd(3, v); chk("R1 border2", v, 0);
    regRd(4, v); chk("R1 perm", v, 16'h0777);
    chk("R1 outputs", {segIrq, pucReq, pwdViol}, 0);

    // R7 wrong key
    regWr(0, 16'h5A11);
    chk("R7 pwdViol pulse", pwdViol, 1);
    regRd(0, v); chk("R7 ctrl unchanged", v, 0);
    @(negedge clk);
    chk("R7 pwdViol drops", pwdViol, 0);

    regWr(2, 16'h0600);
    regWr(3, 16'h0800);
    // R6 disabled: no report
    regWr(4, 16'h0757);
    access(20'h6002, 2'd1);
    regRd(1, v); chk("R6 no flag when off", v, 0);
    chk("R6 no puc when off", pucReq, 0);

    regWr(0, 16'hA511);
    regRd(0, v); chk("R7 ctrl loaded", v, 16'h0011);

    // R2 R3 R4 R9 sweep
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 3; k++) begin
        regWr(4, 16'h0777 & ~(16'h1 << (s * 4 + k)));
        for (int ai = 0; ai < 11; ai++) begin
          for (int k2 = 0; k2 < 4; k2++) begin
            access(addrs[ai], 2'(k2));
            e = (k2 == k && expSeg(addrs[ai], 16'h0600, 16'h0800) == s) ? (1 << s) : 0;
            regRd(1, v);
            chk("R2 R3 R4 flag", v, 32'(e));
            chk("R9 irq", segIrq, (e != 0) ? 1 : 0);
            if (e != 0) regWr(1, 16'h0000);
          end
        end
      end
    end

    // R5 reset-reporting segment
    regWr(4, 16'h07D7);
    access(20'h7000, 2'd1);
    chk("R5 puc high", pucReq, 1);
    regRd(1, v); chk("R5 no flag", v, 0);
    @(negedge clk);
    chk("R5 puc one clock", pucReq, 0);
    access(20'h5000, 2'd1);
    chk("R5 allowed segment no puc", pucReq, 0);

    // R8 clear by zero, set wins
    regWr(4, 16'h0575);
    access(20'h5000, 2'd1);
    access(20'h9000, 2'd1);
    regRd(1, v); chk("R8 two flags", v, 16'h0005);
    regWr(1, 16'h0004);
    regRd(1, v); chk("R8 partial clear", v, 16'h0004);
    @(negedge clk);
    busValid = 1'b1; busAddr = 20'h5000; busKind = 2'd1;
    regWrEn = 1'b1; regSel = 3'd1; regWdata = 16'h0000;
    @(negedge clk);
    busValid = 1'b0; regWrEn = 1'b0;
    regRd(1, v); chk("R8 set beats clear", v, 16'h0001);

    // R9 interrupt gating
    regWr(0, 16'hA501);
    chk("R9 irq masked", segIrq, 0);
    regRd(1, v); chk("R9 flag kept", v, 16'h0001);
    regWr(0, 16'hA511);
    chk("R9 irq unmasked", segIrq, 1);
    regWr(1, 16'h0000);
    chk("R9 irq clears", segIrq, 0);

    // R11 inverted borders
    regWr(2, 16'h0800);
    regWr(3, 16'h0600);
    regWr(4, 16'h0757);
    for (int ai = 0; ai < 11; ai++) begin
      access(addrs[ai], 2'd1);
      regRd(1, v); chk("R11 middle empty", v, 0);
    end
    regWr(4, 16'h0775);
    for (int ai = 0; ai < 11; ai++) begin
      access(addrs[ai], 2'd1);
      e = (expSeg(addrs[ai], 16'h0800, 16'h0600) == 0) ? 1 : 0;
      regRd(1, v); chk("R11 low segment extends", v, 32'(e));
      regWr(1, 16'h0000);
    end

    // R10 lock
    regWr(0, 16'hA513);
    regRd(0, v); chk("R10 locked ctrl", v, 16'h0013);
    regWr(2, 16'h1234);
    regWr(3, 16'h0111);
    regWr(4, 16'h0000);
    regWr(0, 16'hA500);
    regRd(2, v); chk("R10 border1 frozen", v, 16'h0800);
    regRd(3, v); chk("R10 border2 frozen", v, 16'h0600);
    regRd(4, v); chk("R10 perm frozen", v, 16'h0775);
    regRd(0, v); chk("R10 ctrl frozen", v, 16'h0013);
    access(20'h5000, 2'd1);
    regRd(1, v); chk("R10 flag set while locked", v, 16'h0001);
    regWr(1, 16'h0000);
    regRd(1, v); chk("R10 flag clear while locked", v, 0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    regRd(0, v); chk("R10 reset releases lock", v, 0);
    regRd(2, v); chk("R10 reset clears border1", v, 0);
    regWr(0, 16'hA511);
    regRd(0, v); chk("R10 writable after reset", v, 16'h0011);

    finishRun();
  end
endmodule